// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer and Identifier

This block gathers the four interrupt conditions of a UART (receive line status, receive buffer full, transmit buffer empty and modem status) into one pending latch per source. An enable register masks three of them. The highest-priority source that is pending and unmasked is reported through a read-only identification register. That register carries a 2-bit source code and a flag that is set when nothing is pending. A single interrupt request output goes high whenever anything unmasked is pending.

The UART datapath sends a one-cycle set pulse for each source event. Software reaches the block over a simple register bus with read and write strobes. Each source is retired by the bus access that naturally services it, so a handler can read the identification register, act on the reported source, and loop until the no-interrupt flag returns.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification register reads 0x01, the enable register reads 0x00, and `irq_o` is low.
- R2: The enable register is at address 0. Its bit 2 masks line status, bit 1 masks transmit empty and bit 0 masks receive full. Bits 7..3 always read 0, and writes to them are ignored.
- R3: `irq_o` is high exactly when at least one pending source is unmasked. The modem status source has no enable bit and is never masked.
- R4: The identification register is at address 1. Bit 0 is 1 when nothing unmasked is pending. Bits 2..1 hold the source code (11 line status, 10 receive full, 01 transmit empty, 00 modem status) and read 00 when nothing is pending. Bits 7..3 read 0. `rdata_o` shows the addressed register combinationally, and side effects occur only on a `rd_i` or `wr_i` strobe.
- R5: When several unmasked sources are pending, the reported code is the highest of them. Line status ranks above receive full, which ranks above transmit empty, which ranks above modem status.
- R6: Clearing an enable bit hides its source but keeps the pending state. Setting the bit again makes the source visible.
- R7: A read strobe at address 2 (line status) clears the line status source.
- R8: A read strobe at address 4 (receive data) clears the receive full source.
- R9: A write strobe at address 5 (transmit data) clears the transmit empty source.
- R10: A read strobe at the identification address clears the transmit empty source only if code 01 with flag 0 was the value returned on that read. Otherwise the source is left pending.
- R11: A read strobe at address 3 (modem status) clears the modem status source. Accesses to any other address do not clear it.
- R12: A set pulse and a clearing access to the same source in the same cycle leave the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | 4 | Per-source set pulses: [3] line status, [2] receive full, [1] transmit empty, [0] modem status |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or lost pending latch appears at the ports on the cycle after the set pulse or clearing access. It shows as a wrong identification code or an `irq_o` level that disagrees with the no-interrupt flag. A faulty priority encoder is visible only when two or more unmasked sources are pending together, so the stimulus table mixes overlapping sets with partial masks. Faults in the side-effect decode surface one access later, when the source is still pending or has gone when it should not have. The conditional clear by an identification read is exercised both when the transmit-empty source is the reported one and when a higher-priority source or a mask hides it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // source index equals the reported priority code
  typedef enum logic [1:0] {
    SRC_MODEM = 2'd0,
    SRC_TXE   = 2'd1,
    SRC_RXF   = 2'd2,
    SRC_RLS   = 2'd3
  } src_e;

  localparam int unsigned NUM_SRC = 4;

  localparam int unsigned REG_EN  = 0;
  localparam int unsigned REG_ID  = 1;
  localparam int unsigned REG_LSR = 2;
  localparam int unsigned REG_MSR = 3;
  localparam int unsigned REG_RXD = 4;
  localparam int unsigned REG_TXD = 5;

  // enable register bit positions
  localparam int unsigned EN_RXF = 0;
  localparam int unsigned EN_TXE = 1;
  localparam int unsigned EN_RLS = 2;
  localparam int unsigned EN_W   = 3;
endpackage

// File: rtl/irq_pend_bit.sv
module irq_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;   // set wins over clear
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned CW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic            any_o,
  output logic [CW-1:0]   code_o
);
  // highest index wins
  always_comb begin
    code_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i]) code_o = CW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NSRC = NUM_SRC,
  localparam int unsigned CW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [CW-1:0]   id_code_i,
  input  logic            id_any_i,
  output logic [NSRC-1:0] en_mask_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rdata_o
);
  logic [EN_W-1:0] en_q;
  logic            sel_en, sel_id, sel_lsr, sel_msr, sel_rxd, sel_txd;
  logic [DW-1:0]   id_val;
  logic            unused_wdata;

  assign sel_en  = (addr_i == AW'(REG_EN));
  assign sel_id  = (addr_i == AW'(REG_ID));
  assign sel_lsr = (addr_i == AW'(REG_LSR));
  assign sel_msr = (addr_i == AW'(REG_MSR));
  assign sel_rxd = (addr_i == AW'(REG_RXD));
  assign sel_txd = (addr_i == AW'(REG_TXD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             en_q <= '0;
    else if (wr_i && sel_en) en_q <= wdata_i[EN_W-1:0];
  end
  assign unused_wdata = ^wdata_i[DW-1:EN_W];

  always_comb begin
    en_mask_o            = '1;
    en_mask_o[SRC_RLS]   = en_q[EN_RLS];
    en_mask_o[SRC_RXF]   = en_q[EN_RXF];
    en_mask_o[SRC_TXE]   = en_q[EN_TXE];
    en_mask_o[SRC_MODEM] = 1'b1;        // no enable bit for modem status
  end

  always_comb begin
    clr_o            = '0;
    clr_o[SRC_RLS]   = rd_i && sel_lsr;
    clr_o[SRC_RXF]   = rd_i && sel_rxd;
    clr_o[SRC_MODEM] = rd_i && sel_msr;
    // transmit empty: data write, or ident read that returned it
    clr_o[SRC_TXE]   = (wr_i && sel_txd) ||
                       (rd_i && sel_id && id_any_i && id_code_i == CW'(SRC_TXE));
  end

  assign id_val = {{(DW-CW-1){1'b0}}, id_code_i, ~id_any_i};

  always_comb begin
    rdata_o = '0;
    if (sel_en)      rdata_o = {{(DW-EN_W){1'b0}}, en_q};
    else if (sel_id) rdata_o = id_val;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 8,
  localparam int unsigned NS = NUM_SRC,
  localparam int unsigned CW = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] set_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NS-1:0] pend, clr, en_mask, live;
  logic [CW-1:0] code;
  logic          any;

  for (genvar g = 0; g < NS; g++) begin : g_src
    irq_pend_bit u_pend (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_i[g]),
      .clr_i (clr[g]),
      .pend_o(pend[g])
    );
  end

  assign live = pend & en_mask;

  irq_prio_enc #(.NSRC(NS)) u_enc (
    .req_i (live),
    .any_o (any),
    .code_o(code)
  );

  irq_bus_regs #(.AW(AW), .DW(DW), .NSRC(NS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .id_code_i(code),
    .id_any_i (any),
    .en_mask_o(en_mask),
    .clr_o    (clr),
    .rdata_o  (rdata_o)
  );

  assign irq_o = any;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] set_i,
  input logic [AW-1:0]      addr_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DW-1:0]      wdata_i,
  input logic [DW-1:0]      rdata_o,
  input logic               irq_o
);
  logic at_id, at_en;
  logic unused_chk;
  assign at_id = (addr_i == AW'(REG_ID));
  assign at_en = (addr_i == AW'(REG_EN));
  assign unused_chk = ^wdata_i;

  p_flag_vs_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_id |-> (rdata_o[0] == !irq_o));

  p_idle_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_id && rdata_o[0]) |-> (rdata_o[2:1] == 2'b00));

  p_id_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_id |-> (rdata_o[DW-1:3] == '0));

  p_en_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_en |-> (rdata_o[DW-1:3] == '0));

  p_modem_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[SRC_MODEM] |=> irq_o);

  p_no_access_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i && !wr_i) |=> irq_o);

  p_quiet_stays_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && set_i == '0 && !(wr_i && at_en)) |=> !irq_o);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .set_i  (set_i),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A_EN = 3'd0, A_ID = 3'd1, A_LSR = 3'd2,
                            A_MSR = 3'd3, A_RXD = 3'd4, A_TXD = 3'd5;
  // set index: [3] line status, [2] rx full, [1] tx empty, [0] modem
  localparam logic [3:0] S_RLS = 4'b1000, S_RXF = 4'b0100, S_TXE = 4'b0010, S_MOD = 4'b0001;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    set_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_i = 1'b0, wr_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_irq_ident #(.AW(AW), .DW(DW)) u0 (.*);

  // {set[3:0], en[2:0], exp_id[7:0], exp_irq}
  localparam logic [15:0] VEC [0:11] = '{
    {4'b0000, 3'b000, 8'h01, 1'b0},
    {4'b0001, 3'b000, 8'h00, 1'b1},
    {4'b0010, 3'b010, 8'h02, 1'b1},
    {4'b0010, 3'b000, 8'h01, 1'b0},
    {4'b0100, 3'b001, 8'h04, 1'b1},
    {4'b1000, 3'b100, 8'h06, 1'b1},
    {4'b1111, 3'b111, 8'h06, 1'b1},
    {4'b0111, 3'b111, 8'h04, 1'b1},
    {4'b0011, 3'b111, 8'h02, 1'b1},
    {4'b1111, 3'b011, 8'h04, 1'b1},
    {4'b1110, 3'b000, 8'h01, 1'b0},
    {4'b1010, 3'b010, 8'h02, 1'b1}
  };

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_rd(input logic [AW-1:0] a);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] s);
    @(negedge clk_i); set_i = s;
    @(negedge clk_i); set_i = '0;
  endtask

  // look at a register without a read strobe
  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic clear_all();
    bus_rd(A_LSR); bus_rd(A_RXD); bus_rd(A_MSR); bus_wr(A_TXD, 8'h00);
  endtask

  initial begin : watchdog
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    repeat (3) @(negedge clk_i);
    peek(A_ID, v);  chk("R1 id in reset", v, 8'h01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    peek(A_ID, v);  chk("R1 id after reset", v, 8'h01);
    peek(A_EN, v);  chk("R1 enable after reset", v, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);

    // R2: reserved bits
    bus_wr(A_EN, 8'hFF);
    peek(A_EN, v);  chk("R2 enable reserved bits", v, 8'h07);
    bus_wr(A_EN, 8'hA5);
    peek(A_EN, v);  chk("R2 enable low bits", v, 8'h05);

    // table: R3 R4 R5 masking
    for (int i = 0; i < 12; i++) begin
      bus_wr(A_EN, {5'b0, VEC[i][11:9]});
      pulse(VEC[i][15:12]);
      peek(A_ID, v);
      chk($sformatf("R5 vec%0d id", i), v, VEC[i][8:1]);
      chk($sformatf("R3 vec%0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][0]});
      clear_all();
      peek(A_ID, v);
      chk($sformatf("R4 vec%0d idle", i), v, 8'h01);
    end

    // R6: masked state retained
    bus_wr(A_EN, 8'h00);
    pulse(S_TXE);
    chk("R6 masked irq low", {7'b0, irq_o}, 8'h00);
    bus_wr(A_EN, 8'h02);
    peek(A_ID, v);  chk("R6 unmask reveals", v, 8'h02);

    // R9: tx write clears
    bus_wr(A_TXD, 8'h3C);
    peek(A_ID, v);  chk("R9 tx write clears", v, 8'h01);

    // R10: ident read with line status above tx empty
    bus_wr(A_EN, 8'h07);
    pulse(S_RLS | S_TXE);
    bus_rd(A_ID);
    peek(A_ID, v);  chk("R10 hidden txe kept", v, 8'h06);
    bus_rd(A_LSR);
    peek(A_ID, v);  chk("R7 lsr read clears", v, 8'h02);
    bus_rd(A_ID);
    peek(A_ID, v);  chk("R10 reported txe cleared", v, 8'h01);

    // R10: masked tx empty under modem report
    bus_wr(A_EN, 8'h00);
    pulse(S_TXE | S_MOD);
    peek(A_ID, v);  chk("R11 modem unmaskable", v, 8'h00);
    bus_rd(A_ID);
    bus_wr(A_EN, 8'h02);
    peek(A_ID, v);  chk("R10 masked txe kept", v, 8'h02);
    bus_wr(A_TXD, 8'h00);

    // R11: other accesses leave modem; msr read clears
    bus_rd(A_RXD); bus_rd(A_LSR); bus_wr(A_TXD, 8'h11); bus_rd(A_ID);
    peek(A_ID, v);  chk("R11 modem survives others", v, 8'h00);
    bus_rd(A_MSR);
    peek(A_ID, v);  chk("R11 msr read clears", v, 8'h01);

    // R8: rxd read clears
    bus_wr(A_EN, 8'h01);
    pulse(S_RXF);
    bus_rd(A_LSR);
    peek(A_ID, v);  chk("R8 lsr read leaves rxf", v, 8'h04);
    bus_rd(A_RXD);
    peek(A_ID, v);  chk("R8 rxd read clears", v, 8'h01);

    // R12: set and clear in one cycle
    @(negedge clk_i); addr_i = A_MSR; rd_i = 1'b1; set_i = S_MOD;
    @(negedge clk_i); rd_i = 1'b0; set_i = '0;
    peek(A_ID, v);  chk("R12 set beats clear", v, 8'h00);
    chk("R12 irq held", {7'b0, irq_o}, 8'h01);
    @(negedge clk_i); addr_i = A_RXD; rd_i = 1'b1; set_i = S_RXF;
    @(negedge clk_i); rd_i = 1'b0; set_i = '0;
    peek(A_ID, v);  chk("R12 rxf set beats clear", v, 8'h04);
    clear_all();
    peek(A_ID, v);  chk("R4 final idle", v, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule